// File: doc/BRIEF.md
# Dual-Channel Input Capture Controller

This block timestamps events on two external pins against a free-running timer that is supplied from outside. Each pin is first brought into the clock domain. The block then compares each new sample with the one before it. When the edge type chosen for that channel appears, the block copies the timer count into the channel's capture register and raises that channel's pending flag. If the channel's interrupt is enabled, the pending flag also drives an interrupt line.

Software reaches the block through a small register bus. One 8-bit control word holds, for both channels, the edge selection, the interrupt enables and the pending flags. Two further read-only words return the captured counts. Pending flags are cleared by writing a zero into their bit position. Writing a one into a flag position leaves the flag unchanged. A second pair of channels is obtained by instantiating the block again.

Top module: `capture_pair`

## Requirements
- R1: After reset, the control word (address 0) reads 0, both capture words (addresses 1 and 2) read 0, and both interrupt lines are low.
- R2: Control bits [1:0] select the edge for channel 0 and bits [3:2] select it for channel 1. The codes are: 00 detects nothing, 01 detects rising edges, 10 detects falling edges, and 11 detects both.
- R3: A pin change is synchronised through two flip-flops. The flag is still clear two clock edges after the change and is set at the third edge.
- R4: On a valid edge, the capture register takes the timer value present at the clock edge that sets the flag.
- R5: A capture register holds its value when its channel sees no valid edge. Bus writes to addresses 1 and 2 have no effect on the captured values.
- R6: Pending flags are bits 6 (channel 0) and 7 (channel 1) of the control word. Writing 0 to a flag bit clears it, and writing 1 to a flag bit leaves it unchanged.
- R7: Bits 4 and 5 enable the interrupts of channels 0 and 1. Each interrupt line is high exactly while its flag and its enable are both 1.
- R8: When a valid edge and a clearing write to the same flag meet in one cycle, the flag stays set and the capture is still taken.
- R9: Control bits [5:0] read back as last written.
- R10: A pin and the configuration of one channel never change the other channel's flag or capture register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_cnt | input | TMR_W | Free-running timer count |
| cap_pin | input | 2 | Asynchronous capture pins, one per channel |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 2 | Word address: 0 control, 1 capture 0, 2 capture 1 |
| reg_wdata | input | 8 | Write data for the control word |
| reg_rdata | output | TMR_W | Combinational read data for reg_addr |
| irq | output | 2 | Level interrupt for each channel |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same clock cycle as a detected edge. The stimulus toggles a pin, counts the synchroniser edges, and issues the write so that it is active exactly at the edge that registers the event. The bench then checks that the flag stays set and that the capture reflects that cycle's timer value. A sweep covers every edge code, both enable values and both pin directions on each channel. For each case it confirms the flag, the interrupt line and the capture, and it confirms that the idle channel is untouched.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam int unsigned NUM_CH   = 2;
   localparam int unsigned CTL_W    = 8;
   localparam int unsigned SEL_LSB  = 0;
   localparam int unsigned IEN_LSB  = 4;
   localparam int unsigned FLG_LSB  = 6;
   localparam logic [1:0]  ADR_CTL  = 2'd0;
   localparam logic [1:0]  ADR_CAP0 = 2'd1;
   localparam logic [1:0]  ADR_CAP1 = 2'd2;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cap_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_chan.sv
module cap_chan
   import cap_pkg::*;
#(
   parameter int unsigned TMR_W  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  edge_sel_e        sel,
   input  logic [TMR_W-1:0] timer,
   input  logic             clr,
   output logic             hit,
   output logic             flag,
   output logic [TMR_W-1:0] cap
);
   logic smp, prev;

   cap_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin), .q(smp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= smp;
   end

   always_comb begin
      unique case (sel)
         EDGE_RISE: hit = smp & ~prev;
         EDGE_FALL: hit = ~smp & prev;
         EDGE_BOTH: hit = smp ^ prev;
         default:   hit = 1'b0;
      endcase
   end

   // a detected edge takes priority over a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         cap  <= '0;
      end else begin
         flag <= hit | (flag & ~clr);
         if (hit) cap <= timer;
      end
   end
endmodule

// File: rtl/capture_pair.sv
module capture_pair
   import cap_pkg::*;
#(
   parameter int unsigned TMR_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] timer_cnt,
   input  logic [1:0]       cap_pin,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [TMR_W-1:0] reg_rdata,
   output logic [1:0]       irq
);
   localparam int unsigned PAD_W = TMR_W - CTL_W;

   generate
      if (TMR_W < CTL_W) begin : g_bad_w
         $error("capture_pair: TMR_W must be at least 8");
      end
   endgenerate

   logic [NUM_CH-1:0][1:0]       es_q;
   logic [NUM_CH-1:0]            ien_q;
   logic [NUM_CH-1:0]            flag_v;
   logic [NUM_CH-1:0]            hit_v;
   logic [NUM_CH-1:0][TMR_W-1:0] cap_v;
   logic                         ctl_wr;
   logic [CTL_W-1:0]             ctl_rd;

   assign ctl_wr = reg_wr && (reg_addr == ADR_CTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         es_q  <= '0;
         ien_q <= '0;
      end else if (ctl_wr) begin
         for (int i = 0; i < NUM_CH; i++) begin
            es_q[i]  <= reg_wdata[SEL_LSB + 2*i +: 2];
            ien_q[i] <= reg_wdata[IEN_LSB + i];
         end
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         cap_chan #(.TMR_W(TMR_W), .STAGES(SYNC_STAGES)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cap_pin[c]),
            .sel   (edge_sel_e'(es_q[c])),
            .timer (timer_cnt),
            .clr   (ctl_wr & ~reg_wdata[FLG_LSB + c]),
            .hit   (hit_v[c]),
            .flag  (flag_v[c]),
            .cap   (cap_v[c])
         );
         assign irq[c] = flag_v[c] & ien_q[c];
      end
   endgenerate

   assign ctl_rd = {flag_v, ien_q, es_q};

   always_comb begin
      unique case (reg_addr)
         ADR_CTL:  reg_rdata = {{PAD_W{1'b0}}, ctl_rd};
         ADR_CAP0: reg_rdata = cap_v[0];
         ADR_CAP1: reg_rdata = cap_v[1];
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/capture_pair_chk.sv
module capture_pair_chk #(
   parameter int unsigned TMR_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr,
   input logic [1:0]            reg_addr,
   input logic [7:0]            reg_wdata,
   input logic [TMR_W-1:0]      timer_cnt,
   input logic [1:0]            flag_v,
   input logic [1:0]            hit_v,
   input logic [1:0][1:0]       es_q,
   input logic [1:0][TMR_W-1:0] cap_v
);
   generate
      for (genvar i = 0; i < 2; i++) begin : g_c
         // R6
         flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_v[i]) |-> $past(reg_wr && reg_addr == 2'd0 && !reg_wdata[6+i]));
         // R4
         cap_at_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_v[i] |=> (cap_v[i] == $past(timer_cnt)));
         // R8
         keep_on_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_v[i] |=> flag_v[i]);
         // R2
         off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (es_q[i] == 2'b00) |=> $stable(cap_v[i]));
      end
   endgenerate
endmodule

bind capture_pair capture_pair_chk #(.TMR_W(TMR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .timer_cnt(timer_cnt), .flag_v(flag_v),
   .hit_v(hit_v), .es_q(es_q), .cap_v(cap_v)
);

// File: tb/capture_pair_test.sv
module capture_pair_test;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] tmr = 16'h1234;
   logic [1:0]    pin = 2'b00;
   logic          wr = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [7:0]    wdata = 8'h00;
   logic [TW-1:0] rdata;
   logic [1:0]    irq;

   int n_vec = 0;
   int n_bad = 0;
   logic [TW-1:0] exp_cap [2];

   capture_pair uut (
      .clk(clk), .rst_n(rst_n), .timer_cnt(tmr), .cap_pin(pin),
      .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq(irq)
   );

   always #5 clk = ~clk;
   always @(posedge clk) tmr <= tmr + 16'h0103;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk);
      addr = 2'd0; wdata = v; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [TW-1:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec + 1, n_bad);
      $finish;
   end

   initial begin
      logic [TW-1:0] v, et;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1
      rd(2'd0, v); check("R1 ctl", v, 0);
      rd(2'd1, v); check("R1 cap0", v, 0);
      rd(2'd2, v); check("R1 cap1", v, 0);
      check("R1 irq", irq, 0);
      exp_cap[0] = '0; exp_cap[1] = '0;

      // R9 and R6: config readback, writing 1 to flags does nothing
      wr_ctl(8'hFF); rd(2'd0, v); check("R9 all ones", v, 16'h003F);
      wr_ctl(8'hD5); rd(2'd0, v); check("R9 pattern", v, 16'h0015);
      // R5: writes to capture addresses are ignored
      @(negedge clk); addr = 2'd1; wdata = 8'hA5; wr = 1'b1;
      @(negedge clk); addr = 2'd2;
      @(negedge clk); wr = 1'b0;
      rd(2'd1, v); check("R5 cap0 write ignored", v, 0);
      rd(2'd2, v); check("R5 cap1 write ignored", v, 0);

      // R2 R3 R4 R7 R10 sweep
      for (int ch = 0; ch < 2; ch++) begin
         for (int code = 0; code < 4; code++) begin
            for (int en = 0; en < 2; en++) begin
               for (int d = 0; d < 2; d++) begin
                  logic [7:0] cfg;
                  logic rise, det;
                  int oc;
                  oc = 1 - ch;
                  cfg = 8'((code << (2*ch)) | (en << (4+ch)));
                  wr_ctl(cfg);
                  rd(2'd0, v); check("R6 clear by zero", v, {8'h00, cfg});
                  @(negedge clk);
                  pin[ch] = ~pin[ch];
                  rise = pin[ch];
                  det = (code == 3) || (code == 1 && rise) || (code == 2 && !rise);
                  @(posedge clk); @(posedge clk);
                  @(negedge clk);
                  et = tmr;
                  check("R3 no flag before third edge", rdata[6+ch], 0);
                  @(negedge clk);
                  #1;
                  check("R3/R2 flag", rdata[6+ch], det);
                  check("R7 irq", irq[ch], det & en[0]);
                  check("R10 other irq", irq[oc], 0);
                  if (det) exp_cap[ch] = et;
                  rd(2'(1+ch), v); check("R4/R5 capture", v, exp_cap[ch]);
                  rd(2'(1+oc), v); check("R10 other capture", v, exp_cap[oc]);
                  rd(2'd0, v); check("R10 other flag", v[6+oc], 0);
               end
            end
         end
      end

      // R6 write-1 keeps flag, R7 irq follows flag
      wr_ctl(8'h13);
      @(negedge clk); pin[0] = ~pin[0];
      repeat (4) @(negedge clk);
      rd(2'd1, v); exp_cap[0] = v;
      check("R7 irq set", irq[0], 1);
      wr_ctl(8'hD3); rd(2'd0, v); check("R6 write one keeps", v[6], 1);
      check("R7 irq held", irq[0], 1);
      wr_ctl(8'h13); rd(2'd0, v); check("R6 write zero clears", v[6], 0);
      check("R7 irq drops", irq[0], 0);

      // R8: clearing write lands on the edge that sets the flag
      wr_ctl(8'h53);
      @(negedge clk); pin[0] = ~pin[0];
      repeat (4) @(negedge clk);
      rd(2'd0, v); check("R8 pre flag", v[6], 1);
      @(negedge clk); pin[0] = ~pin[0];
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      et = tmr;
      addr = 2'd0; wdata = 8'h13; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      #1 check("R8 flag kept", rdata[6], 1);
      rd(2'd1, v); check("R8 capture taken", v, et);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule